// File: doc/BRIEF.md
# Third-Order Cascaded-Accumulator Noise Shaper

This block turns a multi-bit unsigned word into a short signed code for a DAC with only a few levels. Three first-order accumulators are chained. The first adds the input word on every accepted sample. The second adds the registered sum held by the first. The third adds the registered sum held by the second. Each accumulator wraps modulo 2^W, and its carry-out is a one-bit stream. A differencing network then merges the three carry streams. It adds stage one's carry, the first difference of stage two's carry and the second difference of stage three's carry, each delayed so that the three terms line up in time. The quantisation error of the first two stages cancels. Only the third stage's error is left, shaped by three zeros at DC. The long-run mean of the output code equals the input divided by 2^W.

Samples enter and leave through valid/ready handshakes. An input word is taken when `in_valid` and `in_ready` are both high at a clock edge. Each accepted word produces exactly one output code, which is registered and offered on the next cycle. The input side is ready whenever the output register is empty or is being drained in the same cycle. So back-pressure on `out_ready` stalls the whole modulator. No accumulator or delay register moves while the output waits, and the output code is held unchanged.

Top module: `mash3_shaper`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all three accumulators, all carry delay registers and `out_valid` to zero. The first cycle after reset shows `out_valid` = 0 and `in_ready` = 1.
- R2: On each accepted sample, stage one forms acc1 + in_data. It keeps the low W bits and takes bit W as its carry c1.
- R3: On each accepted sample, stage two adds the value stage one held before that sample, giving carry c2. Stage three adds the value stage two held before that sample, giving carry c3.
- R4: The output code for accepted sample n is c1[n-2] + c2[n-1] - c2[n-2] + c3[n] - 2*c3[n-1] + c3[n-2]. Here index n-k means the carry of the k-th previously accepted sample, and it is zero before the first sample after reset.
- R5: `out_data` is a 4-bit two's-complement code and is always within -3..+4 when `out_valid` is high.
- R6: For a constant input x over N accepted samples from reset, the sum of the output codes is within 4 of N*x/2^W.
- R7: `in_ready` equals (not `out_valid`) or `out_ready`. A sample is accepted only when `in_valid` and `in_ready` are both high, and each accepted sample sets `out_valid` on the next cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` stays stable and the modulator state does not advance, whatever `in_data` is.
- R9: A zero input stream applied from reset yields an output code of 0 for every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Modulator can accept a word |
| in_data | input | W | Unsigned input word |
| out_valid | output | 1 | Output code valid |
| out_ready | input | 1 | Downstream accepts the code |
| out_data | output | 4 | Signed output code, -3..+4 |

## Verification
The bench aims at the alignment of the delayed carry terms. A design that drops one delay, or uses the new sum instead of the held sum between stages, gives codes that are off by one or two on particular samples. Such a design also loses the exact mean, and the long constant-input runs catch that. Random stalls check that back-pressure freezes the state. A design that advances its accumulators during a stall, or lets the code change while it waits, goes out of step with the reference sequence. Inputs of zero and full scale check the zero-output case and the wrap of the carry at the top of the range.

// File: rtl/mash3_pkg.sv
package mash3_pkg;
  localparam int STAGES = 3;
  localparam int CODE_W = 4;
  typedef logic signed [CODE_W-1:0] code_t;
endpackage

// File: rtl/mash3_accum.sv
module mash3_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum_q,
  output logic         carry
);
  logic [W:0] ext;

  always_comb begin
    ext   = {1'b0, sum_q} + {1'b0, addend};
    carry = ext[W];
  end

  always_ff @(posedge clk) begin
    if (rst)     sum_q <= '0;
    else if (en) sum_q <= ext[W-1:0];
  end

  // R8: state frozen when no sample is taken
  p_hold_state_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sum_q));
endmodule

// File: rtl/mash3_recombine.sv
module mash3_recombine
  import mash3_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [STAGES-1:0] carry,
  output code_t             code
);
  logic c1_d1, c1_d2, c2_d1, c2_d2, c3_d1, c3_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      {c1_d1, c1_d2, c2_d1, c2_d2, c3_d1, c3_d2} <= '0;
    end else if (en) begin
      c1_d1 <= carry[0];
      c1_d2 <= c1_d1;
      c2_d1 <= carry[1];
      c2_d2 <= c2_d1;
      c3_d1 <= carry[2];
      c3_d2 <= c3_d1;
    end
  end

  // aligned: c1 two samples late, c2 first difference one late, c3 second difference
  always_comb begin
    code = $signed({3'b000, c1_d2})
         + $signed({3'b000, c2_d1}) - $signed({3'b000, c2_d2})
         + $signed({3'b000, carry[2]}) - $signed({2'b00, c3_d1, 1'b0})
         + $signed({3'b000, c3_d2});
  end

  // R5: merged code bounded
  p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
    en |-> (code >= -4'sd3 && code <= 4'sd4));
endmodule

// File: rtl/mash3_shaper.sv
module mash3_shaper
  import mash3_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [3:0]   out_data
);
  logic              fire;
  logic [W-1:0]      addend [STAGES];
  logic [W-1:0]      held   [STAGES];
  logic [STAGES-1:0] carry;
  code_t             code;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign addend[g] = in_data;
      end else begin : g_tail
        assign addend[g] = held[g-1];
      end
      mash3_accum #(.W(W)) u_acc (
        .clk(clk), .rst(rst), .en(fire),
        .addend(addend[g]), .sum_q(held[g]), .carry(carry[g])
      );
    end
  endgenerate

  mash3_recombine u_rec (
    .clk(clk), .rst(rst), .en(fire), .carry(carry), .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= code;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: empty right after reset
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
  // R7: every accepted sample is offered next cycle
  p_accept_valid_r7: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);
  // R8: stalled code held
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R5: offered code in range
  p_out_range_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_data) >= -4'sd3 && $signed(out_data) <= 4'sd4));
endmodule

// File: tb/mash3_shaper_tb.sv
module mash3_shaper_tb_top;
  localparam int W = 8;
  localparam int Q = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [3:0]   out_data;

  always #2 clk = ~clk;

  mash3_shaper #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  int m1, m2, m3;
  int c1a, c1b, c2a, c2b, c3a, c3b;
  int out_sum;
  bit stall_prev;
  logic [3:0] stall_data;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference built from R2, R3, R4
  task automatic model_step(input int x, output int y);
    int s1, s2, s3, k1, k2, k3;
    s1 = m1 + x;  k1 = s1 / Q;
    s2 = m2 + m1; k2 = s2 / Q;
    s3 = m3 + m2; k3 = s3 / Q;
    m1 = s1 % Q; m2 = s2 % Q; m3 = s3 % Q;
    y = c1b + c2a - c2b + k3 - 2 * c3a + c3b;
    c1b = c1a; c1a = k1;
    c2b = c2a; c2a = k2;
    c3b = c3a; c3a = k3;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m1 = 0; m2 = 0; m3 = 0;
    c1a = 0; c1b = 0; c2a = 0; c2b = 0; c3a = 0; c3b = 0;
    exp_q.delete();
    stall_prev = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  // one cycle: drive at negedge, score handshakes before next posedge
  task automatic cycle(input bit iv, input int x, input bit ordy, input string req);
    int y, act;
    if (stall_prev) begin
      check(out_valid && out_data == stall_data, "R8 stalled code held",
            int'($signed(out_data)), int'($signed(stall_data)));
    end
    in_valid = iv; in_data = x[W-1:0]; out_ready = ordy;
    #1;
    check(in_ready == (!out_valid || out_ready), "R7 in_ready rule",
          int'(in_ready), int'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      act = int'($signed(out_data));
      y = (exp_q.size() > 0) ? exp_q.pop_front() : 99;
      out_sum += act;
      check(act == y, req, act, y);
      check(act >= -3 && act <= 4, "R5 code range", act, 0);
    end
    stall_prev = out_valid && !out_ready;
    stall_data = out_data;
    if (iv && in_ready) begin
      model_step(x, y);
      exp_q.push_back(y);
    end
    @(negedge clk);
  endtask

  task automatic const_run(input int x, input int n, input string req);
    do_reset();
    out_sum = 0;
    for (int i = 0; i < n; i++) cycle(1'b1, x, 1'b1, req);
    cycle(1'b0, 0, 1'b1, req);
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();

    // R9: zero input yields zero codes
    const_run(0, 64, "R9 zero input R4");
    check(out_sum == 0, "R9 zero sum", out_sum, 0);

    // R6: mean over long constant runs
    const_run(64, 1024, "R4 const 64");
    check(out_sum >= 252 && out_sum <= 260, "R6 mean x=64", out_sum, 256);
    const_run(Q - 1, 1024, "R2 full scale R4");
    check(out_sum >= 1016 && out_sum <= 1024, "R6 mean x=max", out_sum, 1020);
    const_run(1, 1024, "R3 small input R4");
    check(out_sum >= 0 && out_sum <= 8, "R6 mean x=1", out_sum, 4);

    // random traffic with stalls (R7, R8) and random words (R2, R3, R4)
    do_reset();
    for (int i = 0; i < 20000; i++) begin
      int x;
      bit iv, ordy;
      x    = int'($urandom_range(Q - 1));
      iv   = ($urandom_range(3) != 0);
      ordy = ($urandom_range(3) != 0);
      cycle(iv, x, ordy, "R4 random");
    end
    cycle(1'b0, 0, 1'b1, "R4 drain");
    check(exp_q.size() == 0, "R7 one output per input", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule